// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Assist Registers

This block is a fully associative address translation buffer that hardware never refills by itself. Software builds and inspects entries through a bank of staging registers, called assist registers here. A write-and-readback register port reaches them. A one-cycle command strobe then moves data between the staging registers and the entry array. There are four commands: fetch an entry into the staging registers, commit the staging registers into an entry, look up a page number, and drop every entry whose page number matches an address.

The array holds 16 entries for fixed 4 KB pages. Each entry carries a valid flag, an address-space bit, an 8-bit process tag, a 20-bit effective page, a 20-bit physical page, four user bits and six permission bits. A lookup reports success through the valid bit it leaves in the staging registers.

When the surrounding pipeline sees a translation miss, it pulses the miss-report input with the faulting page and address space. The staging registers are then preset from a defaults register and a round-robin victim index, so a refill handler only has to supply the physical page and the attribute bits before committing.

Within one cycle a miss report takes precedence over a command for assist registers 0 to 3, and a command takes precedence over a register-port write to them. Array updates from a command are never blocked.

Top module: `soft_tlb`

## Requirements
- R1: After reset every assist register reads zero, no entry is valid, and the victim index is 0.
- R2: The register port writes and reads assist registers at addresses 0, 1, 2, 3, 4 and 6. The fields are:
  - address 0: select in bits [1:0], entry index in bits [11:8];
  - address 1: valid in bit 31, address space in bit 30, process tag in bits [7:0];
  - address 2: effective page in bits [19:0];
  - address 3: physical page in bits [19:0], user bits in [23:20], permissions in [29:24];
  - address 4: default valid in bit 31, default process tag in [15:8], default select in [1:0];
  - address 6: lookup address space in bit 0, lookup process tag in [15:8].
  Addresses 5 and 7, and every other bit, read zero.
- R3: Command opcode 0 (fetch) with select value 01 copies the indexed entry into assist registers 1 to 3 in one clock.
- R4: Opcode 1 (commit) with select value 01 writes the contents of assist registers 1 to 3 into the indexed entry.
- R5: With any select value other than 01, a commit leaves the array unchanged and a fetch loads zeros into assist registers 1 to 3.
- R6: Opcode 2 (lookup) matches valid entries whose effective page equals cmd_epn and whose address space and process tag equal those in assist register 6. On a hit it sets select to 01 and the index to the hit entry, and loads that entry into registers 1 to 3 with valid set.
- R7: A lookup that misses clears only the valid bit of assist register 1 and leaves all other staging fields unchanged.
- R8: When several entries match a lookup, the lowest-numbered one is reported.
- R9: Opcode 3 (drop) clears the valid bit of every valid entry whose effective page equals cmd_epn, whatever its address space or process tag.
- R10: A miss report loads the following:
  - select from the default select, and the index from the victim index;
  - valid from the default valid, address space from miss_as, and process tag from the default tag;
  - effective page from miss_epn;
  - zero into register 3.
- R11: The victim index advances by one, wrapping from 15 to 0, after each commit with select 01 whose index equals the current victim. Commits to any other index leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Assist register write strobe |
| reg_addr | input | 3 | Assist register address |
| reg_wdata | input | 32 | Assist register write data |
| reg_rdata | output | 32 | Assist register read data (combinational from reg_addr) |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 fetch, 1 commit, 2 lookup, 3 drop |
| cmd_epn | input | 20 | Page number for lookup and drop |
| miss_valid | input | 1 | Translation miss report strobe |
| miss_as | input | 1 | Address space of the faulting access |
| miss_epn | input | 20 | Page number of the faulting access |

## Verification
The bench builds the block with its default of 16 entries. With that size the 4-bit victim pointer can be driven through a full wrap within a few dozen commits. Random page numbers and process tags are drawn from small sets, so random lookups hit often and drops clear several entries at once. Directed cases place identical entries at two indices to expose the lowest-index rule, and exercise non-live select values and the unmapped register addresses.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int REG_W     = 32;
  localparam int AR_ADDR_W = 3;
  localparam int EPN_W     = 20;
  localparam int RPN_W     = 20;
  localparam int PID_W     = 8;
  localparam int USR_W     = 4;
  localparam int PRM_W     = 6;
  localparam int SEL_W     = 2;

  localparam logic [SEL_W-1:0] SEL_LIVE = 2'b01;

  // assist register addresses
  localparam logic [AR_ADDR_W-1:0] AR_CTL  = 3'd0;
  localparam logic [AR_ADDR_W-1:0] AR_TAG  = 3'd1;
  localparam logic [AR_ADDR_W-1:0] AR_PAGE = 3'd2;
  localparam logic [AR_ADDR_W-1:0] AR_PHYS = 3'd3;
  localparam logic [AR_ADDR_W-1:0] AR_DFLT = 3'd4;
  localparam logic [AR_ADDR_W-1:0] AR_KEY  = 3'd6;

  // field positions inside assist registers
  localparam int IDX_LSB  = 8;
  localparam int VLD_BIT  = 31;
  localparam int AS_BIT   = 30;
  localparam int TAG_LSB  = 8;
  localparam int USR_LSB  = 20;
  localparam int PRM_LSB  = 24;

  typedef enum logic [1:0] {
    OP_FETCH  = 2'd0,
    OP_COMMIT = 2'd1,
    OP_LOOKUP = 2'd2,
    OP_DROP   = 2'd3
  } tlb_op_e;

  typedef struct packed {
    logic             vld;
    logic             as;
    logic [PID_W-1:0] pid;
    logic [EPN_W-1:0] epn;
    logic [RPN_W-1:0] rpn;
    logic [USR_W-1:0] usr;
    logic [PRM_W-1:0] prm;
  } tlb_entry_t;
endpackage

// File: rtl/soft_tlb_array.sv
module soft_tlb_array
  import soft_tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  tlb_entry_t               wr_data,
  input  logic                     drop_en,
  input  logic [EPN_W-1:0]         drop_epn,
  output tlb_entry_t [NUM_ENT-1:0] ents_o
);

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    tlb_entry_t ent_q;
    tlb_entry_t ent_d;
    logic       hit_wr;
    logic       hit_drop;
    logic       ent_en;

    // next-state for one entry: commit wins over drop (they never coincide)
    always_comb begin
      hit_wr   = wr_en && (wr_idx == IDX_W'(g));
      hit_drop = drop_en && ent_q.vld && (ent_q.epn == drop_epn);
      ent_en   = hit_wr || hit_drop;
      ent_d    = ent_q;
      if (hit_wr) begin
        ent_d = wr_data;
      end else if (hit_drop) begin
        ent_d.vld = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign ents_o[g] = ent_q;
  end

endmodule

// File: rtl/soft_tlb_match.sv
module soft_tlb_match
  import soft_tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  tlb_entry_t [NUM_ENT-1:0] ents,
  input  logic [EPN_W-1:0]         key_epn,
  input  logic                     key_as,
  input  logic [PID_W-1:0]         key_pid,
  output logic [NUM_ENT-1:0]       raw_o,
  output logic [NUM_ENT-1:0]       grant_o,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o
);

  logic found;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign raw_o[g] = ents[g].vld &&
                      (ents[g].epn == key_epn) &&
                      (ents[g].as  == key_as) &&
                      (ents[g].pid == key_pid);
  end

  // lowest index wins
  always_comb begin
    found   = 1'b0;
    grant_o = '0;
    idx_o   = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (raw_o[i] && !found) begin
        found      = 1'b1;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end

  assign hit_o = found;

endmodule

// File: rtl/soft_tlb_victim.sv
module soft_tlb_victim #(
  parameter int NUM_ENT = 16,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;

  always_comb begin
    ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/soft_tlb_assist.sv
module soft_tlb_assist
  import soft_tlb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [AR_ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 ld_en,
  input  logic                 ld_ctl,
  input  logic [IDX_W-1:0]     ld_idx,
  input  tlb_entry_t           ld_data,
  input  logic                 clr_vld,
  input  logic                 miss_en,
  input  logic                 miss_as,
  input  logic [EPN_W-1:0]     miss_epn,
  input  logic [IDX_W-1:0]     victim,
  output logic [SEL_W-1:0]     sel_o,
  output logic [IDX_W-1:0]     idx_o,
  output tlb_entry_t           stg_o,
  output logic                 key_as_o,
  output logic [PID_W-1:0]     key_pid_o
);

  // control register
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ctl_en;
  // staged entry (registers 1..3)
  tlb_entry_t       stg_q, stg_d;
  logic             stg_en;
  // defaults
  logic             dvld_q, dvld_d;
  logic [PID_W-1:0] dpid_q, dpid_d;
  logic [SEL_W-1:0] dsel_q, dsel_d;
  logic             dflt_en;
  // lookup key
  logic             kas_q, kas_d;
  logic [PID_W-1:0] kpid_q, kpid_d;
  logic             key_en;

  always_comb begin
    sel_d   = sel_q;
    idx_d   = idx_q;
    ctl_en  = 1'b0;
    stg_d   = stg_q;
    stg_en  = 1'b0;
    dvld_d  = dvld_q;
    dpid_d  = dpid_q;
    dsel_d  = dsel_q;
    dflt_en = 1'b0;
    kas_d   = kas_q;
    kpid_d  = kpid_q;
    key_en  = 1'b0;

    if (miss_en) begin
      sel_d     = dsel_q;
      idx_d     = victim;
      ctl_en    = 1'b1;
      stg_d     = '0;
      stg_d.vld = dvld_q;
      stg_d.as  = miss_as;
      stg_d.pid = dpid_q;
      stg_d.epn = miss_epn;
      stg_en    = 1'b1;
    end else if (ld_en) begin
      stg_d  = ld_data;
      stg_en = 1'b1;
      if (ld_ctl) begin
        sel_d  = SEL_LIVE;
        idx_d  = ld_idx;
        ctl_en = 1'b1;
      end
    end else if (clr_vld) begin
      stg_d.vld = 1'b0;
      stg_en    = 1'b1;
    end else if (reg_wr) begin
      case (reg_addr)
        AR_CTL: begin
          sel_d  = reg_wdata[SEL_W-1:0];
          idx_d  = reg_wdata[IDX_LSB +: IDX_W];
          ctl_en = 1'b1;
        end
        AR_TAG: begin
          stg_d.vld = reg_wdata[VLD_BIT];
          stg_d.as  = reg_wdata[AS_BIT];
          stg_d.pid = reg_wdata[PID_W-1:0];
          stg_en    = 1'b1;
        end
        AR_PAGE: begin
          stg_d.epn = reg_wdata[EPN_W-1:0];
          stg_en    = 1'b1;
        end
        AR_PHYS: begin
          stg_d.rpn = reg_wdata[RPN_W-1:0];
          stg_d.usr = reg_wdata[USR_LSB +: USR_W];
          stg_d.prm = reg_wdata[PRM_LSB +: PRM_W];
          stg_en    = 1'b1;
        end
        default: ;
      endcase
    end

    // defaults and lookup key are never written by commands or misses
    if (reg_wr && reg_addr == AR_DFLT) begin
      dvld_d  = reg_wdata[VLD_BIT];
      dpid_d  = reg_wdata[TAG_LSB +: PID_W];
      dsel_d  = reg_wdata[SEL_W-1:0];
      dflt_en = 1'b1;
    end
    if (reg_wr && reg_addr == AR_KEY) begin
      kas_d  = reg_wdata[0];
      kpid_d = reg_wdata[TAG_LSB +: PID_W];
      key_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      idx_q <= '0;
    end else if (ctl_en) begin
      sel_q <= sel_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else if (stg_en) begin
      stg_q <= stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvld_q <= 1'b0;
      dpid_q <= '0;
      dsel_q <= '0;
    end else if (dflt_en) begin
      dvld_q <= dvld_d;
      dpid_q <= dpid_d;
      dsel_q <= dsel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kas_q  <= 1'b0;
      kpid_q <= '0;
    end else if (key_en) begin
      kas_q  <= kas_d;
      kpid_q <= kpid_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AR_CTL: begin
        reg_rdata[SEL_W-1:0]       = sel_q;
        reg_rdata[IDX_LSB +: IDX_W] = idx_q;
      end
      AR_TAG: begin
        reg_rdata[VLD_BIT]    = stg_q.vld;
        reg_rdata[AS_BIT]     = stg_q.as;
        reg_rdata[PID_W-1:0]  = stg_q.pid;
      end
      AR_PAGE: reg_rdata[EPN_W-1:0] = stg_q.epn;
      AR_PHYS: begin
        reg_rdata[RPN_W-1:0]        = stg_q.rpn;
        reg_rdata[USR_LSB +: USR_W] = stg_q.usr;
        reg_rdata[PRM_LSB +: PRM_W] = stg_q.prm;
      end
      AR_DFLT: begin
        reg_rdata[VLD_BIT]           = dvld_q;
        reg_rdata[TAG_LSB +: PID_W]  = dpid_q;
        reg_rdata[SEL_W-1:0]         = dsel_q;
      end
      AR_KEY: begin
        reg_rdata[0]                 = kas_q;
        reg_rdata[TAG_LSB +: PID_W]  = kpid_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign sel_o     = sel_q;
  assign idx_o     = idx_q;
  assign stg_o     = stg_q;
  assign key_as_o  = kas_q;
  assign key_pid_o = kpid_q;

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [AR_ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [EPN_W-1:0]     cmd_epn,
  input  logic                 miss_valid,
  input  logic                 miss_as,
  input  logic [EPN_W-1:0]     miss_epn
);

  localparam int               IDX_W   = $clog2(NUM_ENT);
  localparam logic [IDX_W:0]   ENT_LIM = (IDX_W + 1)'(NUM_ENT);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  tlb_entry_t [NUM_ENT-1:0] ents;
  tlb_entry_t               stg;
  tlb_entry_t               ld_data;
  logic [SEL_W-1:0]         ar_sel;
  logic [IDX_W-1:0]         ar_idx;
  logic                     key_as;
  logic [PID_W-1:0]         key_pid;
  logic [IDX_W-1:0]         vic_ptr;
  logic [NUM_ENT-1:0]       m_raw;
  logic [NUM_ENT-1:0]       m_grant;
  logic                     m_hit;
  logic [IDX_W-1:0]         m_idx;

  logic is_fetch, is_commit, is_lookup, is_drop;
  logic live, wr_en, vic_adv;
  logic ld_en, ld_ctl, clr_vld;

  // command decode
  always_comb begin
    is_fetch  = cmd_valid && (cmd_op == OP_FETCH);
    is_commit = cmd_valid && (cmd_op == OP_COMMIT);
    is_lookup = cmd_valid && (cmd_op == OP_LOOKUP);
    is_drop   = cmd_valid && (cmd_op == OP_DROP);
    live      = (ar_sel == SEL_LIVE) && ({1'b0, ar_idx} < ENT_LIM);
    wr_en     = is_commit && live;
    vic_adv   = wr_en && (ar_idx == vic_ptr);
  end

  // staging load source
  always_comb begin
    ld_en   = 1'b0;
    ld_ctl  = 1'b0;
    clr_vld = 1'b0;
    ld_data = '0;
    if (is_fetch) begin
      ld_en = 1'b1;
      if (live) begin
        ld_data = ents[ar_idx];
      end
    end else if (is_lookup) begin
      if (m_hit) begin
        ld_en   = 1'b1;
        ld_ctl  = 1'b1;
        ld_data = ents[m_idx];
      end else begin
        clr_vld = 1'b1;
      end
    end
  end

  soft_tlb_array #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_idx   (ar_idx),
    .wr_data  (stg),
    .drop_en  (is_drop),
    .drop_epn (cmd_epn),
    .ents_o   (ents)
  );

  soft_tlb_match #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_match (
    .ents    (ents),
    .key_epn (cmd_epn),
    .key_as  (key_as),
    .key_pid (key_pid),
    .raw_o   (m_raw),
    .grant_o (m_grant),
    .hit_o   (m_hit),
    .idx_o   (m_idx)
  );

  soft_tlb_victim #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_victim (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (vic_adv),
    .ptr_o (vic_ptr)
  );

  soft_tlb_assist #(.IDX_W(IDX_W)) u_assist (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ld_en     (ld_en),
    .ld_ctl    (ld_ctl),
    .ld_idx    (m_idx),
    .ld_data   (ld_data),
    .clr_vld   (clr_vld),
    .miss_en   (miss_valid),
    .miss_as   (miss_as),
    .miss_epn  (miss_epn),
    .victim    (vic_ptr),
    .sel_o     (ar_sel),
    .idx_o     (ar_idx),
    .stg_o     (stg),
    .key_as_o  (key_as),
    .key_pid_o (key_pid)
  );

endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk
  import soft_tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int IDX_W   = $clog2(NUM_ENT)
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic                     cmd_valid,
  input logic [1:0]               cmd_op,
  input logic [EPN_W-1:0]         cmd_epn,
  input logic                     miss_valid,
  input logic [EPN_W-1:0]         miss_epn,
  input logic [SEL_W-1:0]         ar_sel,
  input logic [IDX_W-1:0]         ar_idx,
  input tlb_entry_t               stg,
  input logic [IDX_W-1:0]         vic_ptr,
  input tlb_entry_t [NUM_ENT-1:0] ents,
  input logic                     m_hit,
  input logic [NUM_ENT-1:0]       m_grant,
  input logic [NUM_ENT-1:0]       m_raw
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  logic [EPN_W-1:0] drop_epn_q;
  logic             drop_left;
  logic             commit_vic;

  always_ff @(posedge clk) begin
    drop_epn_q <= cmd_epn;
  end

  always_comb begin
    drop_left = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ents[i].vld && ents[i].epn == drop_epn_q) drop_left = 1'b1;
    end
  end

  assign commit_vic = cmd_valid && (cmd_op == OP_COMMIT) &&
                      (ar_sel == SEL_LIVE) && (ar_idx == vic_ptr);

  // R11: victim steps and wraps on a commit to its own index
  a_r11_victim_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    commit_vic |=> vic_ptr == (($past(vic_ptr) == LAST) ? '0 : $past(vic_ptr) + 1'b1));

  // R11: victim holds otherwise
  a_r11_victim_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !commit_vic |=> $stable(vic_ptr));

  // R8: at most one entry is reported, and only one that matched
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(m_grant) && ((m_grant & ~m_raw) == '0));

  // R7: lookup miss clears staged valid and keeps the page
  a_r7_miss_clears_vld: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_op == OP_LOOKUP && !m_hit && !miss_valid)
    |=> (!stg.vld && stg.epn == $past(stg.epn) && stg.rpn == $past(stg.rpn)));

  // R6: lookup hit reports a live select and a valid staged entry
  a_r6_hit_loads: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_op == OP_LOOKUP && m_hit && !miss_valid)
    |=> (stg.vld && ar_sel == SEL_LIVE && stg.epn == $past(cmd_epn)));

  // R9: no valid entry with the dropped page survives
  a_r9_drop_clean: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_op == OP_DROP) |=> !drop_left);

  // R10: miss preload of page and victim index
  a_r10_miss_preload: assert property (@(posedge clk) disable iff (!rst_sync_n)
    miss_valid |=> (stg.epn == $past(miss_epn) && ar_idx == $past(vic_ptr) && stg.rpn == '0));

  // R5: commit with a non-live select leaves the array alone
  a_r5_dead_commit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_op == OP_COMMIT && ar_sel != SEL_LIVE) |=> $stable(ents));

  // R5: fetch with a non-live select zeroes the staged entry
  a_r5_dead_fetch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && cmd_op == OP_FETCH && ar_sel != SEL_LIVE && !miss_valid) |=> stg == '0);

endmodule

bind soft_tlb soft_tlb_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_epn    (cmd_epn),
  .miss_valid (miss_valid),
  .miss_epn   (miss_epn),
  .ar_sel     (ar_sel),
  .ar_idx     (ar_idx),
  .stg        (stg),
  .vic_ptr    (vic_ptr),
  .ents       (ents),
  .m_hit      (m_hit),
  .m_grant    (m_grant),
  .m_raw      (m_raw)
);

// File: tb/soft_tlb_bench.sv
module soft_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NENT       = 16;
  localparam int N_RANDOM   = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [19:0] cmd_epn = '0;
  logic        miss_valid = 1'b0;
  logic        miss_as = 1'b0;
  logic [19:0] miss_epn = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  soft_tlb #(.NUM_ENT(NENT)) u_soft_tlb (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_epn    (cmd_epn),
    .miss_valid (miss_valid),
    .miss_as    (miss_as),
    .miss_epn   (miss_epn)
  );

  // ---------------- reference model ----------------
  typedef struct {
    bit        v;
    bit        a;
    bit [7:0]  pid;
    bit [19:0] epn;
    bit [19:0] rpn;
    bit [3:0]  usr;
    bit [5:0]  prm;
  } ment_t;

  ment_t    me [NENT];
  ment_t    ms;
  bit [1:0] m_sel;
  bit [3:0] m_idx;
  bit       m_dv;
  bit [7:0] m_dpid;
  bit [1:0] m_dsel;
  bit       m_kas;
  bit [7:0] m_kpid;
  int       m_vic;

  function automatic ment_t zent();
    ment_t z;
    z.v = 0; z.a = 0; z.pid = 0; z.epn = 0; z.rpn = 0; z.usr = 0; z.prm = 0;
    return z;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NENT; i++) me[i] = zent();
    ms = zent();
    m_sel = 0; m_idx = 0; m_dv = 0; m_dpid = 0; m_dsel = 0;
    m_kas = 0; m_kpid = 0; m_vic = 0;
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    logic [31:0] r = '0;
    case (a)
      0: begin r[1:0] = m_sel; r[11:8] = m_idx; end
      1: begin r[31] = ms.v; r[30] = ms.a; r[7:0] = ms.pid; end
      2: r[19:0] = ms.epn;
      3: begin r[19:0] = ms.rpn; r[23:20] = ms.usr; r[29:24] = ms.prm; end
      4: begin r[31] = m_dv; r[15:8] = m_dpid; r[1:0] = m_dsel; end
      6: begin r[0] = m_kas; r[15:8] = m_kpid; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic void model_reg(int a, logic [31:0] d);
    case (a)
      0: begin m_sel = d[1:0]; m_idx = d[11:8]; end
      1: begin ms.v = d[31]; ms.a = d[30]; ms.pid = d[7:0]; end
      2: ms.epn = d[19:0];
      3: begin ms.rpn = d[19:0]; ms.usr = d[23:20]; ms.prm = d[29:24]; end
      4: begin m_dv = d[31]; m_dpid = d[15:8]; m_dsel = d[1:0]; end
      6: begin m_kas = d[0]; m_kpid = d[15:8]; end
      default: ;
    endcase
  endfunction

  function automatic void model_cmd(logic [1:0] op, logic [19:0] epn);
    int hit;
    case (op)
      2'd0: ms = (m_sel == 2'b01) ? me[m_idx] : zent();
      2'd1: if (m_sel == 2'b01) begin
        me[m_idx] = ms;
        if (int'(m_idx) == m_vic) m_vic = (m_vic + 1) % NENT;
      end
      2'd2: begin
        hit = -1;
        for (int i = NENT - 1; i >= 0; i--)
          if (me[i].v && me[i].epn == epn && me[i].a == m_kas && me[i].pid == m_kpid) hit = i;
        if (hit >= 0) begin
          ms = me[hit]; m_sel = 2'b01; m_idx = 4'(hit);
        end else begin
          ms.v = 0;
        end
      end
      default: for (int i = 0; i < NENT; i++)
        if (me[i].v && me[i].epn == epn) me[i].v = 0;
    endcase
  endfunction

  function automatic void model_miss(bit as, logic [19:0] epn);
    m_sel = m_dsel; m_idx = 4'(m_vic);
    ms = zent();
    ms.v = m_dv; ms.a = as; ms.pid = m_dpid; ms.epn = epn;
  endfunction

  // ---------------- stimulus and checks ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_regs(string tag);
    int addrs[6] = '{0, 1, 2, 3, 4, 6};
    foreach (addrs[k]) begin
      reg_addr = 3'(addrs[k]);
      #1;
      chk(tag, reg_rdata, exp_rd(addrs[k]));
    end
  endtask

  task automatic op_reg(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    model_reg(a, d);
  endtask

  task automatic op_cmd(logic [1:0] op, logic [19:0] epn);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_epn = epn;
    @(negedge clk);
    cmd_valid = 1'b0;
    model_cmd(op, epn);
  endtask

  task automatic op_miss(bit as, logic [19:0] epn);
    @(negedge clk);
    miss_valid = 1'b1; miss_as = as; miss_epn = epn;
    @(negedge clk);
    miss_valid = 1'b0;
    model_miss(as, epn);
  endtask

  // place an entry through the staging registers
  task automatic put_entry(int idx, bit as, logic [7:0] pid, logic [19:0] epn, logic [19:0] rpn);
    op_reg(0, {20'h0, 4'(idx), 6'h0, 2'b01});
    op_reg(1, {1'b1, as, 22'h0, pid});
    op_reg(2, {12'h0, epn});
    op_reg(3, {2'b00, 6'h2A, 4'h5, rpn});
    op_cmd(2'd1, '0);
  endtask

  task automatic peek_entry(int idx, string tag);
    op_reg(0, {20'h0, 4'(idx), 6'h0, 2'b01});
    op_cmd(2'd0, '0);
    check_regs(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_71B0));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_regs("R1");
    op_miss(1'b0, 20'h12345);
    check_regs("R1 victim zero at reset");
    op_reg(0, 32'h0000_0001);
    op_cmd(2'd0, '0);
    check_regs("R1 entry invalid at reset");

    // R2 field layout and unmapped addresses
    op_reg(0, 32'hFFFF_FFFF);
    reg_addr = 3'd0; #1; chk("R2 ctl mask", reg_rdata, 32'h0000_0F03);
    op_reg(5, 32'hFFFF_FFFF);
    op_reg(7, 32'hFFFF_FFFF);
    reg_addr = 3'd5; #1; chk("R2 addr5", reg_rdata, 32'h0);
    reg_addr = 3'd7; #1; chk("R2 addr7", reg_rdata, 32'h0);
    op_reg(4, 32'hFFFF_FFFF);
    op_reg(6, 32'hFFFF_FFFF);
    check_regs("R2");
    op_reg(4, 32'h0);
    op_reg(6, 32'h0);

    // R4 / R3 commit then fetch
    put_entry(5, 1'b1, 8'h01, 20'h00003, 20'hABCDE);
    op_reg(1, 32'h0); op_reg(2, 32'h0); op_reg(3, 32'h0);
    peek_entry(5, "R3 R4");

    // R5 non-live select
    op_reg(0, {20'h0, 4'd5, 6'h0, 2'b10});
    op_reg(2, 32'h0000_0777);
    op_cmd(2'd1, '0);
    op_cmd(2'd0, '0);
    check_regs("R5 dead fetch zero");
    peek_entry(5, "R5 dead commit no effect");

    // R8 duplicate entries: lowest index wins
    put_entry(9, 1'b0, 8'h01, 20'h00004, 20'h11111);
    put_entry(3, 1'b0, 8'h01, 20'h00004, 20'h22222);
    op_reg(6, {16'h0, 8'h01, 8'h00});
    op_cmd(2'd2, 20'h00004);
    check_regs("R8 lowest index");
    reg_addr = 3'd0; #1; chk("R8 idx", reg_rdata, 32'h0000_0301);

    // R6 hit, R7 miss
    op_reg(6, {16'h0, 8'h01, 8'h01});
    op_cmd(2'd2, 20'h00003);
    check_regs("R6 hit");
    op_cmd(2'd2, 20'h00009);
    check_regs("R7 miss clears valid");

    // R9 drop matches page only
    put_entry(1, 1'b0, 8'h07, 20'h00006, 20'h33333);
    put_entry(2, 1'b1, 8'h09, 20'h00006, 20'h44444);
    op_cmd(2'd3, 20'h00006);
    peek_entry(1, "R9 drop entry 1");
    peek_entry(2, "R9 drop entry 2");

    // R10 miss preload with defaults
    op_reg(3, 32'h3FFF_FFFF);
    op_reg(4, {1'b1, 15'h0, 8'hC3, 6'h0, 2'b01});
    op_miss(1'b1, 20'hF00D5);
    check_regs("R10 preload");

    // R11 wrap of the victim, and commits elsewhere not advancing it
    for (int k = 0; k < NENT + 2; k++) begin
      put_entry(m_vic, 1'b0, 8'h00, 20'(k), 20'(k));
      op_miss(1'b0, 20'h0ABCD);
      check_regs("R11 victim step");
    end
    put_entry((m_vic + 3) % NENT, 1'b0, 8'h00, 20'h5, 20'h5);
    op_miss(1'b0, 20'h0ABCE);
    check_regs("R11 victim hold");

    // random mix
    for (int n = 0; n < N_RANDOM; n++) begin
      int r = int'($urandom % 100);
      if (r < 12) begin
        logic [1:0] s = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
        op_reg(0, {20'($urandom), 4'($urandom), 6'($urandom), s});
        check_regs("R2 random ctl");
      end else if (r < 22) begin
        op_reg(1, {1'($urandom), 1'($urandom), 22'($urandom), 7'h0, 1'($urandom)});
        check_regs("R2 random tag");
      end else if (r < 30) begin
        op_reg(2, {12'($urandom), 17'h0, 3'($urandom)});
        check_regs("R2 random page");
      end else if (r < 36) begin
        op_reg(3, $urandom);
        check_regs("R2 random phys");
      end else if (r < 40) begin
        op_reg(6, {16'($urandom), 7'h0, 1'($urandom), 7'($urandom), 1'($urandom)});
        check_regs("R2 random key");
      end else if (r < 43) begin
        op_reg(4, {$urandom} & 32'h8000_FF03 | 32'h0000_0001);
        check_regs("R2 random defaults");
      end else if (r < 55) begin
        op_cmd(2'd0, '0);
        check_regs("R3 random fetch");
      end else if (r < 70) begin
        op_cmd(2'd1, '0);
        op_cmd(2'd0, '0);
        check_regs("R4 random commit");
      end else if (r < 85) begin
        op_cmd(2'd2, 20'($urandom % 8));
        check_regs("R6 random lookup");
      end else if (r < 93) begin
        op_cmd(2'd3, 20'($urandom % 8));
        op_cmd(2'd0, '0);
        check_regs("R9 random drop");
      end else begin
        op_miss(1'($urandom), 20'($urandom));
        check_regs("R10 random miss");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule